// File: doc/BRIEF.md
# Handshake Pulse Synchronizer

This block moves single-cycle event strobes from one clock domain into another whose clock has no known relation to the first. A strobe accepted on the source side flips a request toggle. That toggle crosses into the destination domain through a two-flop synchronizer. The destination turns each change of the synchronized toggle into a one-cycle pulse, and it returns the sampled toggle as an acknowledge. The acknowledge crosses back to the source through a second two-flop synchronizer.

The source side offers a `ready` output. While an event is still in flight, `ready` is low and any strobe is dropped. When the acknowledge toggle matches the request toggle again, `ready` goes high. The block therefore never holds more than one event in flight, and every accepted strobe gives exactly one destination pulse.

The source control is a two-state machine:
- `SRC_IDLE` (`ready` high). On `send` it takes the `SEND_ACCEPT` transition, which flips the request toggle and moves to `SRC_WAIT`.
- `SRC_WAIT` (`ready` low). Once the synchronized acknowledge equals the request toggle, it takes the `ACK_RETURN` transition back to `SRC_IDLE`. `send` has no effect while in `SRC_WAIT`.

The destination side holds no state machine. It is a single delay flop and an XOR.

Top module: `pulse_bridge`

## Requirements
- R1: While `src_rst_n` and `dst_rst_n` are low and right after they are released, `ready` is 1 and `pulse_out` is 0. Both toggles reset to 0.
- R2: Each accepted send gives exactly one `pulse_out` assertion, and that assertion lasts exactly one destination cycle. A send is accepted when `send` and `ready` are both 1 at a rising `src_clk` edge.
- R3: The pulse goes high at the second rising `dst_clk` edge after the request toggle changes. It is therefore seen within three destination periods of the accepting source edge.
- R4: `ready` is 0 in the cycle after an accepted send. It stays 0 until the synchronized acknowledge equals the request toggle, and only then does it return to 1.
- R5: `send` has no effect while `ready` is 0. No extra pulse appears, and the request toggle does not change.
- R6: Two consecutive accepted sends are at least two destination periods plus two source periods apart.
- R7: Each direction uses a two-flop synchronizer with no logic between the launching flop and the first capture flop. The first capture flop feeds only the second, so the pulse never appears earlier than one full destination period after the send.
- R8: R2 to R6 hold both when the destination clock is faster than the source clock and when it is slower.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain reset, active low |
| send | input | 1 | Event strobe, sampled when ready is 1 |
| ready | output | 1 | High when a new send is accepted |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain reset, active low |
| pulse_out | output | 1 | One-cycle event pulse in the destination domain |

## Verification
The bench tries three kinds of send pattern:
- **Isolated strobes with idle gaps.** These show the basic latency bound, and show that each event yields exactly one pulse.
- **`send` held high for many cycles.** This is the case that separates correct dropping of strobes during `SRC_WAIT` from duplicated or lost events. It also puts every acceptance right at the minimum spacing.
- **Irregular gaps.** These move the strobes to different points in the round trip.

All three patterns run first with a destination clock faster than the source clock and then with one more than twice as slow. The fast run catches a missing synchronizer stage through the lower latency bound. The slow run stresses the upper bound and the acknowledge wait.

// File: rtl/pb_pkg.sv
package pb_pkg;
    typedef enum logic {
        SRC_IDLE = 1'b0,
        SRC_WAIT = 1'b1
    } src_state_e;
endpackage

// File: rtl/pb_sync.sv
// Multi-flop synchronizer: the input lands directly in the first stage,
// and every stage feeds only the next one.
module pb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pb_src.sv
// Source-side control: accepts one event at a time and waits for the
// returning acknowledge toggle before accepting another.
module pb_src
    import pb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic send,
    input  logic ack_in,
    output logic ready,
    output logic req_tgl
);
    src_state_e state_q, state_d;
    logic       req_q, req_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SRC_IDLE;
            req_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            req_q   <= req_d;
        end
    end

    always_comb begin
        state_d = state_q;
        req_d   = req_q;
        unique case (state_q)
            SRC_IDLE: begin
                if (send) begin
                    // SEND_ACCEPT
                    req_d   = ~req_q;
                    state_d = SRC_WAIT;
                end
            end
            SRC_WAIT: begin
                if (ack_in == req_q) begin
                    // ACK_RETURN
                    state_d = SRC_IDLE;
                end
            end
            default: state_d = SRC_IDLE;
        endcase
    end

    always_comb begin
        ready   = (state_q == SRC_IDLE);
        req_tgl = req_q;
    end
endmodule

// File: rtl/pb_dst.sv
// Destination side: turns a change of the synchronized request into a
// single-cycle pulse and launches the acknowledge toggle from a flop.
module pb_dst (
    input  logic clk,
    input  logic rst_n,
    input  logic req_sync,
    output logic pulse,
    output logic ack_tgl
);
    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= req_sync;
    end

    assign pulse   = req_sync ^ seen_q;
    assign ack_tgl = seen_q;
endmodule

// File: rtl/pulse_bridge.sv
module pulse_bridge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic src_clk,
    input  logic src_rst_n,
    input  logic send,
    output logic ready,
    input  logic dst_clk,
    input  logic dst_rst_n,
    output logic pulse_out
);
    logic req_tgl;
    logic req_sync;
    logic ack_tgl;
    logic ack_sync;

    pb_src u_src (
        .clk     (src_clk),
        .rst_n   (src_rst_n),
        .send    (send),
        .ack_in  (ack_sync),
        .ready   (ready),
        .req_tgl (req_tgl)
    );

    pb_sync #(.STAGES(SYNC_STAGES)) u_fwd_sync (
        .clk   (dst_clk),
        .rst_n (dst_rst_n),
        .d     (req_tgl),
        .q     (req_sync)
    );

    pb_dst u_dst (
        .clk      (dst_clk),
        .rst_n    (dst_rst_n),
        .req_sync (req_sync),
        .pulse    (pulse_out),
        .ack_tgl  (ack_tgl)
    );

    pb_sync #(.STAGES(SYNC_STAGES)) u_back_sync (
        .clk   (src_clk),
        .rst_n (src_rst_n),
        .d     (ack_tgl),
        .q     (ack_sync)
    );
endmodule

// File: rtl/pulse_bridge_chk.sv
module pulse_bridge_chk (
    input logic src_clk,
    input logic src_rst_n,
    input logic dst_clk,
    input logic dst_rst_n,
    input logic send,
    input logic ready,
    input logic pulse_out,
    input logic req_tgl,
    input logic ack_seen
);
    // R4: an accepted send drops ready in the next source cycle
    p_ready_drops_r4: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        (send && ready) |=> !ready);

    // R4: ready only comes back once the acknowledge matches the request
    p_ack_before_ready_r4: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        $rose(ready) |-> (ack_seen == req_tgl));

    // R5: while not ready, the request toggle does not move
    p_toggle_held_r5: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        (!ready) |=> $stable(req_tgl));

    // R2: the destination pulse is exactly one cycle wide
    p_pulse_single_r2: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        pulse_out |=> !pulse_out);
endmodule

bind pulse_bridge pulse_bridge_chk u_chk (
    .src_clk   (src_clk),
    .src_rst_n (src_rst_n),
    .dst_clk   (dst_clk),
    .dst_rst_n (dst_rst_n),
    .send      (send),
    .ready     (ready),
    .pulse_out (pulse_out),
    .req_tgl   (req_tgl),
    .ack_seen  (ack_sync)
);

// File: tb/pulse_bridge_test.sv
`timescale 1ns/1ps
module pulse_bridge_test;
    logic src_clk = 1'b0;
    logic dst_clk = 1'b0;
    logic src_rst_n = 1'b0;
    logic dst_rst_n = 1'b0;
    logic send = 1'b0;
    logic ready;
    logic pulse_out;

    real    src_per  = 10.0;
    real    dst_half = 3.6;
    int     checks   = 0;
    int     fails    = 0;
    int     accepts  = 0;
    int     pulses   = 0;
    real    last_acc = -1.0;
    real    exp_q[$];
    logic   prev_pulse = 1'b0;

    pulse_bridge uut (
        .src_clk   (src_clk),
        .src_rst_n (src_rst_n),
        .send      (send),
        .ready     (ready),
        .dst_clk   (dst_clk),
        .dst_rst_n (dst_rst_n),
        .pulse_out (pulse_out)
    );

    always #5 src_clk = ~src_clk;
    initial begin
        #1.3;
        forever #(dst_half) dst_clk = ~dst_clk;
    end

    task automatic report_end();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input real act, input real exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0.2f expected=%0.2f", req, what, act, exp);
        end
    endtask

    // Scoreboard monitor: every destination pulse consumes one expected event.
    always @(negedge dst_clk) begin
        if (dst_rst_n) begin
            if (pulse_out) begin
                real tdst;
                real lat;
                tdst = 2.0 * dst_half;
                pulses++;
                chk(!prev_pulse, "R2", "pulse wider than one cycle", 1, 0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5", "pulse without accepted send", 1, 0);
                end else begin
                    lat = $realtime - exp_q.pop_front();
                    chk(lat > tdst, "R7", "pulse earlier than one dst period", lat, tdst);
                    chk(lat < 3.0 * tdst, "R3", "pulse later than three dst periods", lat, 3.0 * tdst);
                end
            end
            prev_pulse = pulse_out;
        end
    end

    // Driver: hold send for a number of source cycles, recording acceptances.
    task automatic drive(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            logic rdy;
            @(negedge src_clk);
            send = 1'b1;
            rdy  = ready;
            @(posedge src_clk);
            if (rdy) begin
                real min_gap;
                min_gap = 2.0 * (2.0 * dst_half) + 2.0 * src_per;
                accepts++;
                exp_q.push_back($realtime);
                if (last_acc >= 0.0)
                    chk(($realtime - last_acc) >= min_gap, "R6", "send spacing",
                        $realtime - last_acc, min_gap);
                last_acc = $realtime;
                #1;
                chk(ready == 1'b0, "R4", "ready after accepted send", ready, 0);
            end
        end
        @(negedge src_clk);
        send = 1'b0;
    endtask

    task automatic gap(input int n);
        repeat (n) @(negedge src_clk);
    endtask

    task automatic settle(input string tag);
        int w;
        w = 0;
        while (!ready && w < 100) begin
            @(negedge src_clk);
            w++;
        end
        repeat (12) @(negedge src_clk);
        chk(ready == 1'b1, "R4", {tag, " ready restored"}, ready, 1);
        chk(exp_q.size() == 0, "R2", {tag, " events not delivered"}, exp_q.size(), 0);
        chk(pulses == accepts, "R5", {tag, " pulse count vs accepted sends"}, pulses, accepts);
    endtask

    task automatic run_patterns(input string tag);
        last_acc = -1.0;
        for (int k = 0; k < 4; k++) begin
            drive(1);
            gap(25);
        end
        settle({tag, " isolated"});
        last_acc = -1.0;
        drive(60);
        settle({tag, " held send"});
        last_acc = -1.0;
        for (int k = 0; k < 8; k++) begin
            drive(1 + (k % 3));
            gap((k * 7) % 5);
        end
        settle({tag, " irregular"});
    endtask

    initial begin
        #500000;
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        report_end();
    end

    initial begin
        repeat (3) @(negedge src_clk);
        chk(ready == 1'b1, "R1", "ready during reset", ready, 1);
        chk(pulse_out == 1'b0, "R1", "pulse during reset", pulse_out, 0);
        @(negedge src_clk);
        src_rst_n = 1'b1;
        @(negedge dst_clk);
        dst_rst_n = 1'b1;
        repeat (4) @(negedge src_clk);
        chk(ready == 1'b1, "R1", "ready after reset", ready, 1);
        chk(pulse_out == 1'b0, "R1", "pulse after reset", pulse_out, 0);

        // R8: destination faster than source
        dst_half = 3.6;
        run_patterns("R8 fast dst");
        // R8: destination slower than source
        dst_half = 11.7;
        repeat (4) @(negedge src_clk);
        run_patterns("R8 slow dst");

        report_end();
    end
endmodule